// File: doc/BRIEF.md
# Triple-Smoothed Slack Trend Unit

This block turns a stream of slack measurements into a slowly moving trend value. Accepted samples are added into a running sum. Every 1024 accepted samples close a batch, and the batch sum becomes a single snapshot. That snapshot passes through three cascaded exponential moving averages with a weight of 1/64. The output of the third average is the trend. A rising or falling trend shows a drift in path delay rather than short-lived noise.

Only one subtract–shift–add datapath exists. After a batch closes, it is used on three consecutive cycles: first it updates the first average from the snapshot, then the second average from the fresh first one, then the third average from the fresh second one. The accumulator clears as the batch closes, so samples that arrive while the three updates run already count toward the next batch.

Top module: `triple_ema_trend`

## Requirements
- R1: A batch closes on the clock edge that accepts the 1024th sample since reset or since the previous batch closed. The snapshot is the unsigned sum of exactly those samples, and the running sum restarts from zero for the next batch.
- R2: A sample presented while `sample_valid_i` is low is neither added to the sum nor counted toward the batch size.
- R3: Each average updates as `avg <= avg + ((in - avg) >>> 6)`. The difference is signed, and the shift is arithmetic, so it rounds toward minus infinity.
- R4: The first average takes the snapshot as its input. The second takes the first average as already updated for this batch. The third takes the second average as already updated for this batch.
- R5: The three updates happen on the three clock edges that follow the batch-closing edge. `trend_valid_o` is high for exactly one cycle, starting at the third of those edges. `trend_o` changes only in a cycle in which `trend_valid_o` is high.
- R6: Samples accepted in the cycles while an update sequence is running are counted into the next batch.
- R7: After reset, all three averages are zero, `trend_o` is 0, `trend_valid_o` is low, and the sample count and the sum are empty.
- R8: The averages are two's-complement numbers with 6 fractional bits. A snapshot of sum S enters the first average as S*64. The trend is never negative, because every sample is unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Unsigned slack sample |
| sample_valid_i | input | 1 | Qualifies `sample_i` for this cycle |
| trend_o | output | 25 | Triple-smoothed trend, signed, 6 fractional bits |
| trend_valid_o | output | 1 | One-cycle strobe marking a new trend value |

## Verification
The assertions assume that a batch is always longer than the three-cycle update sequence, so a new batch never closes while an update is still running. With 1024 samples per batch, no input pattern can break this. The range assertion also assumes that the samples are unsigned and that the batch sum fits its accumulator. The stimulus consists of 8-bit unsigned values from a seeded random source, with the valid strobe held high for long runs, so batches close as close together as the inputs allow. Further directed batches, of all-maximum and of all-zero samples, push the averages to their largest positive and largest negative steps.

// File: rtl/triple_ema_trend.sv
module triple_ema_trend #(
  parameter int SAMPLE_W   = 8,
  parameter int BATCH_LOG2 = 10,
  parameter int SHIFT      = 6,
  parameter int FRAC       = 6
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [SAMPLE_W-1:0]                     sample_i,
  input  logic                                    sample_valid_i,
  output logic signed [SAMPLE_W+BATCH_LOG2+FRAC:0] trend_o,
  output logic                                    trend_valid_o
);
  localparam int SUM_W = SAMPLE_W + BATCH_LOG2;
  localparam int AVG_W = SUM_W + FRAC + 1;

  typedef enum logic [1:0] {IDLE, UPD1, UPD2, UPD3} phase_t;

  phase_t                    phase;
  logic [BATCH_LOG2-1:0]     cnt;
  logic [SUM_W-1:0]          acc;
  logic [SUM_W-1:0]          acc_next;
  logic                      close;
  logic signed [AVG_W-1:0]   snap, ema1, ema2, ema3;
  logic signed [AVG_W-1:0]   op_prev, op_in, step, nxt;
  logic signed [AVG_W:0]     diff;
  logic                      valid_q;

  assign acc_next = acc + SUM_W'(sample_i);
  assign close    = sample_valid_i && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      snap <= '0;
    end else if (sample_valid_i) begin
      cnt <= cnt + 1'b1;
      if (close) begin
        acc  <= '0;
        snap <= $signed({1'b0, acc_next, {FRAC{1'b0}}});
      end else begin
        acc <= acc_next;
      end
    end
  end

  always_comb begin
    case (phase)
      UPD1:    begin op_prev = ema1; op_in = snap; end
      UPD2:    begin op_prev = ema2; op_in = ema1; end
      default: begin op_prev = ema3; op_in = ema2; end
    endcase
  end

  assign diff = (AVG_W+1)'(op_in) - (AVG_W+1)'(op_prev);
  assign step = AVG_W'(diff >>> SHIFT);
  assign nxt  = op_prev + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= IDLE;
      ema1    <= '0;
      ema2    <= '0;
      ema3    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (phase == UPD3);
      case (phase)
        IDLE: if (close) phase <= UPD1;
        UPD1: begin ema1 <= nxt; phase <= UPD2; end
        UPD2: begin ema2 <= nxt; phase <= UPD3; end
        UPD3: begin ema3 <= nxt; phase <= IDLE; end
        default: phase <= IDLE;
      endcase
    end
  end

  assign trend_o       = ema3;
  assign trend_valid_o = valid_q;
endmodule

// File: rtl/triple_ema_trend_checker.sv
module triple_ema_trend_checker #(
  parameter int SAMPLE_W   = 8,
  parameter int BATCH_LOG2 = 10,
  parameter int FRAC       = 6
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    sample_valid_i,
  input logic signed [SAMPLE_W+BATCH_LOG2+FRAC:0] trend_o,
  input logic                                    trend_valid_o
);
  localparam int AVG_W = SAMPLE_W + BATCH_LOG2 + FRAC + 1;

  logic [BATCH_LOG2-1:0] seen;
  logic [3:0]            pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
      pipe <= '0;
    end else begin
      if (sample_valid_i) seen <= seen + 1'b1;
      pipe <= {pipe[2:0], sample_valid_i && (&seen)};
    end
  end

  assert_strobe_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trend_valid_o == pipe[3]);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trend_valid_o |=> !trend_valid_o);

  assert_trend_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trend_o) |-> trend_valid_o);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trend_o[AVG_W-1]);
endmodule

bind triple_ema_trend triple_ema_trend_checker #(
  .SAMPLE_W(SAMPLE_W), .BATCH_LOG2(BATCH_LOG2), .FRAC(FRAC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid_i(sample_valid_i),
  .trend_o(trend_o), .trend_valid_o(trend_valid_o)
);

// File: tb/test_triple_ema_trend.sv
`timescale 1ns/1ps
module test_triple_ema_trend;
  localparam int BATCH = 1024;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [7:0]         sample_i = '0;
  logic               sample_valid_i = 1'b0;
  logic signed [24:0] trend_o;
  logic               trend_valid_o;

  int     checks = 0;
  int     errors = 0;
  int     cycles = 0;
  bit     done = 0;
  longint m_sum = 0, e1 = 0, e2 = 0, e3 = 0, exp_trend = 0;
  int     m_cnt = 0;
  int     pend = 0;
  string  tag = "R1";

  triple_ema_trend i_triple_ema_trend (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .sample_valid_i(sample_valid_i),
    .trend_o(trend_o), .trend_valid_o(trend_valid_o)
  );

  always #2.5 clk = ~clk;

  function automatic longint ema_step(longint prev, longint inp);
    return prev + ((inp - prev) >>> 6);
  endfunction

  task automatic check(bit ok, string req, longint got, longint want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic accept(logic [7:0] s);
    m_sum += s;
    m_cnt++;
    if (m_cnt == BATCH) begin
      e1 = ema_step(e1, m_sum <<< 6);
      e2 = ema_step(e2, e1);
      e3 = ema_step(e3, e2);
      exp_trend = e3;
      pend = 4;
      m_sum = 0;
      m_cnt = 0;
    end
  endtask

  task automatic step(bit v, logic [7:0] s);
    bit fire;
    @(negedge clk);
    fire = 0;
    if (pend > 0) begin
      pend--;
      fire = (pend == 0);
    end
    check(trend_valid_o == fire, "R5 strobe", longint'(trend_valid_o), longint'(fire));
    if (fire)
      check(longint'(trend_o) == exp_trend, {"R3 R4 value ", tag}, longint'(trend_o), exp_trend);
    sample_valid_i = v;
    sample_i = s;
    if (v) accept(s);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(trend_o == 0, "R7 trend after reset", longint'(trend_o), 0);
    check(trend_valid_o == 0, "R7 strobe after reset", longint'(trend_valid_o), 0);
    rst_n = 1'b1;

    // R1 R8: full-scale batch, snapshot enters at sum*64
    tag = "R1 R8 max batch";
    for (int i = 0; i < BATCH; i++) step(1, 8'hFF);
    // R6: valid held high through the update window
    tag = "R6 back-to-back";
    for (int i = 0; i < 2 * BATCH; i++) step(1, 8'(i * 7));
    // R2: random gaps with junk on invalid cycles
    tag = "R2 random gaps";
    for (int i = 0; i < 5 * BATCH; i++) begin
      bit v;
      v = ($urandom_range(0, 9) < 7);
      step(v, 8'($urandom));
    end
    // R3: all-zero batches force negative differences
    tag = "R3 zero batches";
    for (int i = 0; i < 2 * BATCH; i++) step(1, 8'h00);
    tag = "R6 random dense";
    for (int i = 0; i < 2 * BATCH; i++) step(1, 8'($urandom));
    for (int i = 0; i < 8; i++) step(0, 8'hAA);
    check(pend == 0, "R5 drained", pend, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        checks++;
        errors++;
        $display("FAIL watchdog expired got %0d expected 0", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule